// File: doc/BRIEF.md
# Context-Aware Register Wipe Controller

This controller sits beside a shared hash engine and makes sure the engine's sensitive working state never carries over from one use to the next. It issues a one-cycle clear strobe into the datapath on three triggers: the asynchronous reset, the engine's completion signal, and a request from an owner identifier different from the one currently recorded. The clear strobe comes with a fill word. That word is either all zeros or a word taken from a random input.

A wipe is not taken on trust. The cycle after each clear strobe, the controller samples a readback bus that carries the ten 32-bit sensitive words: the eight working variables and the two round temporaries. It compares every word with the fill value. A single mismatching bit sends the controller into a sticky error state. In that state it refuses all work until the next reset.

The engine's result is held in a local register when the engine finishes. The register is cleared by an explicit release input or by a change of owner. Requesters hold `req_i` high until `acc_start_o` acknowledges them, so a request made during a wipe is delayed and never lost.

Top module: `wipe_guard`

## Requirements
- R1: While reset is asserted, `clear_o` is 1, `fill_o` is 0, `ready_o`, `err_o` and `result_valid_o` are 0, and `result_o` is 0. After reset is released, `clear_o` stays high for one more cycle. A verify cycle follows, and then `ready_o` rises, provided the readback matched zero.
- R2: A request in the ready state is accepted when no owner is recorded or when `owner_id_i` equals the recorded owner. Acceptance sets `acc_start_o` high in that same cycle. In the next cycle `busy_o` is 1 and `ready_o` is 0.
- R3: When `acc_done_i` is high while the engine is active, `clear_o` is high in the next cycle and for exactly one cycle. `acc_done_i` has no effect in any other state.
- R4: A request whose `owner_id_i` differs from a recorded owner is not accepted in that cycle. It causes a wipe, records the new owner, and is accepted, with `acc_start_o` high, in the first ready cycle after a verify that passes.
- R5: During a wipe, `fill_o` is 0 when `fill_rand_sel_i` was 0 in the cycle that triggered the wipe. When it was 1, `fill_o` is the `rand_word_i` value sampled in that same cycle. The wipe after reset always uses 0.
- R6: `ready_o` is 0 during the wipe cycle and the verify cycle. `busy_o` is 1 while the engine is active, during the wipe cycle and during the verify cycle.
- R7: In the verify cycle, word k of `readback_i`, at bits [k*WORD_W +: WORD_W], is compared with the fill value for every k. Any mismatch raises `err_o` in the next cycle. Otherwise `ready_o` rises in the next cycle.
- R8: `err_o` stays high until reset. While it is high, `ready_o` and `busy_o` are 0 and `acc_start_o` never rises.
- R9: `result_o` takes `acc_result_i` on completion, and `result_valid_o` becomes 1 in the next cycle. `release_i` or an owner-change wipe sets both to 0 in the next cycle. If completion and release occur in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, held until acknowledged |
| owner_id_i | input | ID_W | Identifier of the requesting owner |
| fill_rand_sel_i | input | 1 | 1 selects the random fill word, 0 selects zeros |
| rand_word_i | input | WORD_W | Random fill word from an external source |
| acc_done_i | input | 1 | Engine completion pulse |
| acc_result_i | input | RES_W | Engine result |
| release_i | input | 1 | Clears the held result |
| readback_i | input | N_WORDS*WORD_W | Current contents of the sensitive words |
| acc_start_o | output | 1 | Request acknowledge and engine start |
| clear_o | output | 1 | Wipe strobe into the datapath |
| fill_o | output | WORD_W | Value the datapath writes on a wipe |
| ready_o | output | 1 | Idle and able to accept a request |
| busy_o | output | 1 | Engine active, or a wipe or verify in progress |
| err_o | output | 1 | Sticky wipe-verify failure |
| result_o | output | RES_W | Held result |
| result_valid_o | output | 1 | Held result is valid |

## Verification
The bench builds the controller with WORD_W=8, N_WORDS=3, ID_W=2 and RES_W=16. At that size it can step through all four owner identifiers, both fill modes and repeated sessions by the same owner. It can also inject a single-bit fault into every readback word position in turn, each followed by a reset. A behavioural datapath in the bench writes the fill word when the clear strobe is high. It starts from a scribbled pattern, so the wipe done by reset is visible at the readback.

// File: rtl/wg_pkg.sv
package wg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_WIPE   = 3'd2,
        ST_VERIFY = 3'd3,
        ST_ERROR  = 3'd4
    } wg_state_e;
endpackage

// File: rtl/wg_readback_cmp.sv
module wg_readback_cmp #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 10
) (
    input  logic [N_WORDS*WORD_W-1:0] readback_i,
    input  logic [WORD_W-1:0]         fill_i,
    output logic                      match_o
);
    logic [N_WORDS-1:0] word_eq;

    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        assign word_eq[k] = (readback_i[k*WORD_W +: WORD_W] == fill_i);
    end

    assign match_o = &word_eq;
endmodule

// File: rtl/wg_result_hold.sv
module wg_result_hold #(
    parameter int RES_W = 256
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             capture_i,
    input  logic             wipe_i,
    input  logic [RES_W-1:0] data_i,
    output logic [RES_W-1:0] data_o,
    output logic             valid_o
);
    logic [RES_W-1:0] hold_d, hold_q;
    logic             vld_d, vld_q;

    always_comb begin
        hold_d = hold_q;
        vld_d  = vld_q;
        if (capture_i) begin
            hold_d = data_i;
            vld_d  = 1'b1;
        end else if (wipe_i) begin
            hold_d = '0;
            vld_d  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            hold_q <= hold_d;
            vld_q  <= vld_d;
        end
    end

    assign data_o  = hold_q;
    assign valid_o = vld_q;

    AST_CAPTURE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture_i |=> valid_o) else $error("capture lost"); // R9
    AST_WIPE_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wipe_i && !capture_i) |=> (!valid_o && data_o == '0)) else $error("hold not wiped"); // R9
endmodule

// File: rtl/wipe_guard.sv
module wipe_guard
    import wg_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 10,
    parameter int ID_W    = 8,
    parameter int RES_W   = 256
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      req_i,
    input  logic [ID_W-1:0]           owner_id_i,
    input  logic                      fill_rand_sel_i,
    input  logic [WORD_W-1:0]         rand_word_i,
    input  logic                      acc_done_i,
    input  logic [RES_W-1:0]          acc_result_i,
    input  logic                      release_i,
    input  logic [N_WORDS*WORD_W-1:0] readback_i,
    output logic                      acc_start_o,
    output logic                      clear_o,
    output logic [WORD_W-1:0]         fill_o,
    output logic                      ready_o,
    output logic                      busy_o,
    output logic                      err_o,
    output logic [RES_W-1:0]          result_o,
    output logic                      result_valid_o
);
    localparam int RB_W = N_WORDS * WORD_W;

    typedef struct packed {
        wg_state_e         state;
        logic [ID_W-1:0]   owner;
        logic              owner_vld;
        logic [WORD_W-1:0] fill;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic start_c, capture_c, hold_wipe_c, match_w, switch_c;
    logic [WORD_W-1:0] next_fill_c;
    logic [RB_W-1:0]   rb_w;

    assign rb_w        = readback_i;
    assign next_fill_c = fill_rand_sel_i ? rand_word_i : '0;
    assign switch_c    = ctl_q.owner_vld && (owner_id_i != ctl_q.owner);

    wg_readback_cmp #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) cmp_i (
        .readback_i (rb_w),
        .fill_i     (ctl_q.fill),
        .match_o    (match_w)
    );

    always_comb begin
        ctl_d       = ctl_q;
        start_c     = 1'b0;
        capture_c   = 1'b0;
        hold_wipe_c = release_i;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    if (switch_c) begin
                        ctl_d.state = ST_WIPE;
                        ctl_d.owner = owner_id_i;
                        ctl_d.fill  = next_fill_c;
                        hold_wipe_c = 1'b1;
                    end else begin
                        start_c         = 1'b1;
                        ctl_d.state     = ST_ACTIVE;
                        ctl_d.owner     = owner_id_i;
                        ctl_d.owner_vld = 1'b1;
                    end
                end
            end
            ST_ACTIVE: begin
                if (acc_done_i) begin
                    ctl_d.state = ST_WIPE;
                    ctl_d.fill  = next_fill_c;
                    capture_c   = 1'b1;
                end
            end
            ST_WIPE:   ctl_d.state = ST_VERIFY;
            ST_VERIFY: ctl_d.state = match_w ? ST_IDLE : ST_ERROR;
            ST_ERROR:  ctl_d.state = ST_ERROR;
            default:   ctl_d.state = ST_ERROR;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.state     <= ST_WIPE;
            ctl_q.owner     <= '0;
            ctl_q.owner_vld <= 1'b0;
            ctl_q.fill      <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    wg_result_hold #(.RES_W(RES_W)) hold_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (capture_c),
        .wipe_i    (hold_wipe_c),
        .data_i    (acc_result_i),
        .data_o    (result_o),
        .valid_o   (result_valid_o)
    );

    assign acc_start_o = start_c;
    assign clear_o     = (ctl_q.state == ST_WIPE);
    assign fill_o      = ctl_q.fill;
    assign ready_o     = (ctl_q.state == ST_IDLE);
    assign busy_o      = (ctl_q.state == ST_ACTIVE) || (ctl_q.state == ST_WIPE)
                      || (ctl_q.state == ST_VERIFY);
    assign err_o       = (ctl_q.state == ST_ERROR);

    AST_START_GOES_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_start_o |=> (busy_o && !ready_o)) else $error("start not active"); // R2
    AST_DONE_TRIGGERS_WIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.state == ST_ACTIVE && acc_done_i) |=> clear_o) else $error("no wipe on done"); // R3
    AST_WIPE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_o |=> (!clear_o && busy_o)) else $error("wipe too long"); // R3
    AST_SWITCH_WIPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && req_i && switch_c) |=> clear_o) else $error("owner switch no wipe"); // R4
    AST_NOT_READY_IN_WIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_o |-> !ready_o) else $error("ready during wipe"); // R6
    AST_VERIFY_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.state == ST_VERIFY && !match_w) |=> err_o) else $error("mismatch missed"); // R7
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o) else $error("error cleared"); // R8
    AST_ERR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (!acc_start_o && !ready_o)) else $error("start in error"); // R8
endmodule

// File: tb/wipe_guard_tb_top.sv
module wipe_guard_tb_top;
    localparam int W   = 8;
    localparam int N   = 3;
    localparam int IDW = 2;
    localparam int RW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, sel = 1'b0, done = 1'b0, rel = 1'b0;
    logic [IDW-1:0] oid = '0;
    logic [W-1:0]   rnd = '0;
    logic [RW-1:0]  res = '0;
    logic [N*W-1:0] dp_v, fault_v = '0;
    logic scribble = 1'b1;
    logic start, clr, rdy, bsy, err, rvld;
    logic [W-1:0]  fill;
    logic [RW-1:0] rout;

    int n_chk = 0, n_err = 0, cyc = 0;
    logic have_owner = 1'b0;
    logic [IDW-1:0] cur_owner = '0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (scribble) dp_v <= {N{8'h5A}} ^ 24'h00FF33;
        else if (clr)  dp_v <= {N{fill}} ^ fault_v;
    end

    wipe_guard #(.WORD_W(W), .N_WORDS(N), .ID_W(IDW), .RES_W(RW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .owner_id_i(oid),
        .fill_rand_sel_i(sel), .rand_word_i(rnd), .acc_done_i(done),
        .acc_result_i(res), .release_i(rel), .readback_i(dp_v),
        .acc_start_o(start), .clear_o(clr), .fill_o(fill), .ready_o(rdy),
        .busy_o(bsy), .err_o(err), .result_o(rout), .result_valid_o(rvld)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic do_reset(input logic chk_it);
        @(negedge clk);
        rst_n = 1'b0; scribble = 1'b1; req = 1'b0; done = 1'b0; rel = 1'b0;
        step(); step();
        scribble = 1'b0;
        step();
        if (chk_it) begin
            chk("R1 clear in reset", {63'd0, clr}, 64'd1);
            chk("R1 fill zero", {56'd0, fill}, 64'd0);
            chk("R1 ready/err/valid low", {61'd0, rdy, err, rvld}, 64'd0);
            chk("R1 result zero", {48'd0, rout}, 64'd0);
        end
        rst_n = 1'b1;
        #1;
        if (chk_it) chk("R1 wipe after release", {62'd0, clr, rdy}, 64'd2);
        step();
        if (chk_it) chk("R6 verify not ready", {61'd0, clr, rdy, bsy}, 64'd1);
        step();
        have_owner = 1'b0;
    endtask

    task automatic session(input logic [IDW-1:0] id, input logic s,
                           input logic [W-1:0] r1, input logic [W-1:0] r2,
                           input logic [RW-1:0] rv);
        logic sw;
        sw = have_owner && (id != cur_owner);
        @(negedge clk);
        req = 1'b1; oid = id; sel = s; rnd = r1;
        #1;
        if (sw) begin
            chk("R4 no start on switch", {63'd0, start}, 64'd0);
            step();
            rnd = ~r1;
            chk("R4 wipe on switch", {63'd0, clr}, 64'd1);
            chk("R5 switch fill", {56'd0, fill}, {56'd0, (s ? r1 : 8'h00)});
            chk("R9 switch clears hold", {47'd0, rvld, rout}, 64'd0);
            chk("R6 busy in wipe", {62'd0, rdy, bsy}, 64'd1);
            step();
            chk("R6 not ready verify", {63'd0, rdy}, 64'd0);
            step();
            chk("R4 held request accepted", {62'd0, start, rdy}, 64'd3);
        end else begin
            chk("R2 accept", {62'd0, start, rdy}, 64'd3);
        end
        step();
        req = 1'b0;
        chk("R2 active", {62'd0, bsy, rdy}, 64'd2);
        step();
        chk("R3 no wipe while active", {63'd0, clr}, 64'd0);
        @(negedge clk);
        done = 1'b1; res = rv; rnd = r2;
        step();
        done = 1'b0; rnd = ~r2; res = ~rv;
        chk("R3 wipe on done", {63'd0, clr}, 64'd1);
        chk("R5 done fill", {56'd0, fill}, {56'd0, (s ? r2 : 8'h00)});
        chk("R9 result held", {47'd0, rvld, rout}, {47'd0, 1'b1, rv});
        step();
        chk("R3 single wipe cycle", {62'd0, clr, rdy}, 64'd0);
        step();
        chk("R7 pass to ready", {62'd0, rdy, err}, 64'd2);
        chk("R7 words hold fill", {40'd0, dp_v}, {40'd0, {N{(s ? r2 : 8'h00)}}});
        have_owner = 1'b1;
        cur_owner = id;
    endtask

    initial begin
        do_reset(1'b1);
        chk("R1 readback wiped", {40'd0, dp_v}, 64'd0);
        chk("R1 ready after verify", {62'd0, rdy, err}, 64'd2);

        for (int i = 0; i < 8; i++) begin
            session(IDW'(i / 2), i[0], W'(8'h13 * i + 8'h21), W'(8'h2B * i + 8'h07),
                    RW'(16'h1357 * (i + 1)));
        end

        // completion outside the active state is ignored
        @(negedge clk);
        done = 1'b1; res = 16'hDEAD;
        step();
        done = 1'b0;
        chk("R3 done ignored in idle", {61'd0, clr, rdy, bsy}, 64'd2);
        chk("R3 hold unchanged", {48'd0, rout}, {48'd0, RW'(16'h1357 * 8)});

        // explicit release
        @(negedge clk);
        rel = 1'b1;
        step();
        rel = 1'b0;
        chk("R9 release clears", {47'd0, rvld, rout}, 64'd0);

        // capture beats release in the same cycle
        @(negedge clk);
        req = 1'b1; oid = cur_owner; sel = 1'b0;
        step();
        req = 1'b0;
        @(negedge clk);
        done = 1'b1; rel = 1'b1; res = 16'hBEEF;
        step();
        done = 1'b0; rel = 1'b0;
        chk("R9 capture wins", {47'd0, rvld, rout}, {47'd0, 1'b1, 16'hBEEF});
        step(); step();

        // single-bit fault in every word position
        for (int w = 0; w < N; w++) begin
            do_reset(1'b0);
            session(2'd0, 1'b0, 8'h00, 8'h00, 16'h0001);
            fault_v = '0;
            fault_v[w*W + w] = 1'b1;
            @(negedge clk);
            req = 1'b1; oid = 2'd1; sel = 1'b1; rnd = 8'h6C;
            step(); step(); step();
            chk("R7 mismatch flags error", {62'd0, err, rdy}, 64'd2);
            step(); step();
            chk("R8 error sticky, no start", {60'd0, err, start, rdy, bsy}, 64'd8);
            req = 1'b0;
            fault_v = '0;
            @(negedge clk);
            rst_n = 1'b0;
            #1;
            chk("R8 reset clears error", {63'd0, err}, 64'd0);
        end

        // fault during the reset wipe
        fault_v = 24'h000100;
        do_reset(1'b0);
        step();
        chk("R7 reset wipe fault", {63'd0, err}, 64'd1);
        fault_v = '0;
        do_reset(1'b0);
        chk("R1 clean after reset", {62'd0, rdy, err}, 64'd2);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule